// File: doc/BRIEF.md
# Frame Header Emitter with Snapshot

This block keeps a small set of control registers that a host sets with opcode/value commands: the three stream-enable flags, a three-bit sub-frame enable mask and the range-bin count. A single-cycle frame-complete pulse copies these values into snapshot registers. The block then sends a seven-byte header as a byte stream with a valid/ready handshake. The bytes are a sync byte, a protocol version, a flags byte, the 16-bit frame number (high byte first) and the 16-bit range-bin count (high byte first).

Every header byte comes from the snapshot and never from the live registers. A host write that arrives while a header is being sent does not change that header. It shows up in the next one. The flags byte carries the active sub-frame mask beside the stream bits, so the receiver can see which sub-frames were scheduled for that frame. The two top bits of the flags byte are always zero.

Top module: `frame_hdr_emitter`

## Requirements
- R1: After reset, `hdr_valid` and `hdr_last` are low, the frame number is 0, the stream flags and the sub-frame mask both read 3'b111, and the range-bin count equals `DEF_RANGE_BINS`. The first header after reset therefore has flags byte 0x3F.
- R2: When `cmd_valid` is high, opcode 0x19 loads the sub-frame mask from `cmd_value[2:0]`. Opcode 0x05 loads the stream flags from `cmd_value[2:0]`. Opcode 0x1A loads the range-bin count from `cmd_value[15:0]`.
- R3: A command with any other opcode changes no register. Headers sent after it carry the same flags and range bytes as before it.
- R4: A frame-complete pulse sampled while no header is in flight captures the mask, the stream flags and the range-bin count as they stood before that clock edge. The header reads only this capture, so writes made during the header appear only in later headers.
- R5: The flags byte is {2'b00, mask[2:0], stream[2:0]}. The stream bits are bit 2 = detections, bit 1 = Doppler, bit 0 = range. With mask 111, all streams on gives 0x3F and no streams gives 0x38.
- R6: A header is seven bytes in this order: `SYNC_BYTE`, `VERSION`, flags, frame number [15:8], frame number [7:0], range count [15:8], range count [7:0]. `hdr_last` is high on the seventh byte only.
- R7: While `hdr_valid` is high and `hdr_ready` is low, `hdr_valid`, `hdr_data` and `hdr_last` hold their values into the next cycle.
- R8: The frame number starts at 0 and rises by one each time a header's last byte is accepted. It is a `FRAME_CNT_W`-bit count, zero-extended to 16 bits, that wraps from all ones to 0.
- R9: A frame-complete pulse that arrives while a header is in flight is dropped. It does not restart, extend or duplicate the header, and it does not advance the frame number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_opcode | input | 8 | Command opcode |
| cmd_value | input | 16 | Command value |
| frame_done | input | 1 | Frame-complete pulse; captures the snapshot and starts a header |
| hdr_valid | output | 1 | Header byte valid |
| hdr_ready | input | 1 | Downstream ready for a header byte |
| hdr_data | output | 8 | Header byte |
| hdr_last | output | 1 | Marks the final header byte |

## Verification
The assertions assume that `hdr_ready` may change in any cycle, and that `frame_done` and commands may arrive at any time, including in the same cycle as the last byte handshake. They assume nothing about spacing between these inputs. The random stimulus draws opcodes from the three defined codes and from arbitrary byte values, pulses `frame_done` both while idle and during headers, and stalls `hdr_ready` about a third of the time. Reset is applied only at the start, so the byte-position counter in the checker stays aligned with the header sequence.

// File: rtl/fhe_pkg.sv
package fhe_pkg;
  localparam int MASK_W    = 3;
  localparam int STREAM_W  = 3;
  localparam int FIELD_W   = 16;
  localparam int HDR_BYTES = 7;
  localparam int IDX_W     = $clog2(HDR_BYTES);

  localparam logic [7:0] OP_STREAM   = 8'h05;
  localparam logic [7:0] OP_SUBFRAME = 8'h19;
  localparam logic [7:0] OP_RANGE    = 8'h1A;

  typedef logic [IDX_W-1:0] hdr_idx_t;
  localparam hdr_idx_t LAST_IDX = hdr_idx_t'(HDR_BYTES - 1);

  typedef struct packed {
    logic [MASK_W-1:0]   mask;
    logic [STREAM_W-1:0] stream;
    logic [FIELD_W-1:0]  range_bins;
  } hdr_cfg_t;

  function automatic logic [7:0] pack_flags(input logic [MASK_W-1:0] m,
                                            input logic [STREAM_W-1:0] s);
    return {{(8 - MASK_W - STREAM_W){1'b0}}, m, s};
  endfunction
endpackage

// File: rtl/fhe_ctrl_regs.sv
module fhe_ctrl_regs
  import fhe_pkg::*;
#(
  parameter logic [FIELD_W-1:0] DEF_RANGE_BINS = 16'd512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_opcode,
  input  logic [FIELD_W-1:0] cmd_value,
  output hdr_cfg_t           cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.mask       <= '1;
      cfg.stream     <= '1;
      cfg.range_bins <= DEF_RANGE_BINS;
    end else if (cmd_valid) begin
      case (cmd_opcode)
        OP_SUBFRAME: cfg.mask       <= cmd_value[MASK_W-1:0];
        OP_STREAM:   cfg.stream     <= cmd_value[STREAM_W-1:0];
        OP_RANGE:    cfg.range_bins <= cmd_value;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/fhe_snapshot.sv
module fhe_snapshot
  import fhe_pkg::*;
#(
  parameter logic [FIELD_W-1:0] DEF_RANGE_BINS = 16'd512
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     capture,
  input  hdr_cfg_t live,
  output hdr_cfg_t held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held.mask       <= '1;
      held.stream     <= '1;
      held.range_bins <= DEF_RANGE_BINS;
    end else if (capture) begin
      held <= live;
    end
  end
endmodule

// File: rtl/fhe_hdr_seq.sv
module fhe_hdr_seq
  import fhe_pkg::*;
#(
  parameter logic [7:0] SYNC_BYTE   = 8'hA5,
  parameter logic [7:0] VERSION     = 8'h02,
  parameter int         FRAME_CNT_W = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  hdr_cfg_t snap,
  output logic     idle,
  output logic     hdr_valid,
  input  logic     hdr_ready,
  output logic [7:0] hdr_data,
  output logic     hdr_last
);
  logic                   busy;
  hdr_idx_t               idx;
  hdr_idx_t               nxt_idx;
  logic [FRAME_CNT_W-1:0] frame_cnt;
  logic [FIELD_W-1:0]     fnum16;
  logic [7:0]             nxt_byte;

  assign nxt_idx   = idx + hdr_idx_t'(1);
  assign fnum16    = FIELD_W'(frame_cnt);
  assign idle      = !busy;
  assign hdr_valid = busy;

  // Byte after the current one, taken only from the snapshot.
  always_comb begin
    case (nxt_idx)
      hdr_idx_t'(1): nxt_byte = VERSION;
      hdr_idx_t'(2): nxt_byte = pack_flags(snap.mask, snap.stream);
      hdr_idx_t'(3): nxt_byte = fnum16[15:8];
      hdr_idx_t'(4): nxt_byte = fnum16[7:0];
      hdr_idx_t'(5): nxt_byte = snap.range_bins[15:8];
      hdr_idx_t'(6): nxt_byte = snap.range_bins[7:0];
      default:       nxt_byte = SYNC_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idx       <= '0;
      hdr_data  <= '0;
      hdr_last  <= 1'b0;
      frame_cnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        idx      <= '0;
        hdr_data <= SYNC_BYTE;
        hdr_last <= 1'b0;
      end
    end else if (hdr_ready) begin
      if (idx == LAST_IDX) begin
        busy      <= 1'b0;
        hdr_last  <= 1'b0;
        frame_cnt <= frame_cnt + 1'b1;
      end else begin
        idx      <= nxt_idx;
        hdr_data <= nxt_byte;
        hdr_last <= (nxt_idx == LAST_IDX);
      end
    end
  end
endmodule

// File: rtl/frame_hdr_emitter.sv
module frame_hdr_emitter
  import fhe_pkg::*;
#(
  parameter logic [7:0]  SYNC_BYTE      = 8'hA5,
  parameter logic [7:0]  VERSION        = 8'h02,
  parameter logic [15:0] DEF_RANGE_BINS = 16'd512,
  parameter int          FRAME_CNT_W    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_opcode,
  input  logic [15:0] cmd_value,
  input  logic        frame_done,
  output logic        hdr_valid,
  input  logic        hdr_ready,
  output logic [7:0]  hdr_data,
  output logic        hdr_last
);
  hdr_cfg_t live_cfg;
  hdr_cfg_t snap_cfg;
  logic     seq_idle;
  logic     capture;

  assign capture = frame_done && seq_idle;

  fhe_ctrl_regs #(.DEF_RANGE_BINS(DEF_RANGE_BINS)) u_regs (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_value(cmd_value), .cfg(live_cfg)
  );

  fhe_snapshot #(.DEF_RANGE_BINS(DEF_RANGE_BINS)) u_snap (
    .clk(clk), .rst(rst), .capture(capture), .live(live_cfg), .held(snap_cfg)
  );

  fhe_hdr_seq #(
    .SYNC_BYTE(SYNC_BYTE), .VERSION(VERSION), .FRAME_CNT_W(FRAME_CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(capture), .snap(snap_cfg), .idle(seq_idle),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
    .hdr_last(hdr_last)
  );
endmodule

// File: rtl/fhe_checker.sv
module fhe_checker #(
  parameter logic [7:0] SYNC_BYTE = 8'hA5
) (
  input logic       clk,
  input logic       rst,
  input logic       hdr_valid,
  input logic       hdr_ready,
  input logic [7:0] hdr_data,
  input logic       hdr_last,
  input logic [2:0] snap_mask,
  input logic [2:0] snap_stream
);
  logic [2:0] pos;

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else if (hdr_valid && hdr_ready) pos <= hdr_last ? 3'd0 : pos + 3'd1;
  end

  a_r6_sync_first: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && pos == 3'd0 |-> hdr_data == SYNC_BYTE);

  a_r6_last_position: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |-> hdr_last == (pos == 3'd6));

  a_r5_flags_layout: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && pos == 3'd2 |->
      hdr_data[7:6] == 2'b00 && hdr_data[5:3] == snap_mask && hdr_data[2:0] == snap_stream);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data) && $stable(hdr_last));

  a_r4_snapshot_steady: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && $past(hdr_valid) |-> $stable(snap_mask) && $stable(snap_stream));

  a_r9_no_early_end: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && !(hdr_last && hdr_ready) |=> hdr_valid);
endmodule

bind frame_hdr_emitter fhe_checker #(.SYNC_BYTE(SYNC_BYTE)) u_chk (
  .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .hdr_data(hdr_data), .hdr_last(hdr_last),
  .snap_mask(snap_cfg.mask), .snap_stream(snap_cfg.stream)
);

// File: tb/tb_frame_hdr_emitter.sv
module tb_frame_hdr_emitter;
  localparam logic [7:0]  SYNC  = 8'hA5;
  localparam logic [7:0]  VER   = 8'h02;
  localparam logic [15:0] DEFRB = 16'd512;
  localparam int          FCW   = 5;
  localparam int          FMASK = (1 << FCW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, frame_done = 1'b0, hdr_ready = 1'b0;
  logic [7:0] cmd_opcode = '0;
  logic [15:0] cmd_value = '0;
  logic hdr_valid, hdr_last;
  logic [7:0] hdr_data;

  always #5 clk = ~clk;

  frame_hdr_emitter #(.SYNC_BYTE(SYNC), .VERSION(VER), .DEF_RANGE_BINS(DEFRB),
                      .FRAME_CNT_W(FCW)) dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // reference state
  logic [2:0] r_mask, r_stream, s_mask, s_stream;
  logic [15:0] r_rb, s_rb;
  int m_fn, m_idx;
  bit m_busy, prev_stall;
  logic [7:0] prev_data;
  logic [7:0] cap [7];
  int cap_fn;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    case (i)
      0: return SYNC;
      1: return VER;
      2: return {2'b00, s_mask, s_stream};
      3: return 8'(m_fn >> 8);
      4: return 8'(m_fn);
      5: return s_rb[15:8];
      default: return s_rb[7:0];
    endcase
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      2: return "R5";
      3, 4: return "R8";
      5, 6: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic compare();
    check(hdr_valid == m_busy, "R9 valid", hdr_valid, m_busy);
    if (m_busy) begin
      check(hdr_data == exp_byte(m_idx), tag_of(m_idx), hdr_data, exp_byte(m_idx));
      check(hdr_last == (m_idx == 6), "R6 last", hdr_last, m_idx == 6);
      if (prev_stall) check(hdr_data == prev_data, "R7 hold", hdr_data, prev_data);
    end
  endtask

  task automatic step(input bit cv, input logic [7:0] op, input logic [15:0] val,
                      input bit fd, input bit rdy);
    compare();
    cmd_valid = cv; cmd_opcode = op; cmd_value = val; frame_done = fd; hdr_ready = rdy;
    prev_stall = m_busy && !rdy;
    prev_data  = hdr_data;
    if (m_busy) begin
      if (rdy) begin
        cap[m_idx] = hdr_data;
        if (m_idx == 6) begin
          m_busy = 0;
          cap_fn = m_fn;
          m_fn = (m_fn + 1) & FMASK;
        end else m_idx++;
      end
    end else if (fd) begin
      m_busy = 1; m_idx = 0;
      s_mask = r_mask; s_stream = r_stream; s_rb = r_rb;
    end
    if (cv) begin
      case (op)
        8'h19: r_mask = val[2:0];
        8'h05: r_stream = val[2:0];
        8'h1A: r_rb = val;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle_step(); step(0, 8'h00, 16'h0, 0, 1); endtask
  task automatic cmd(input logic [7:0] op, input logic [15:0] v); step(1, op, v, 0, 1); endtask
  task automatic header();
    step(0, 8'h00, 16'h0, 1, 1);
    for (int k = 0; k < 8; k++) idle_step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed, prev_fn;
    seed = $urandom(32'h5EED_0042);
    r_mask = 3'b111; r_stream = 3'b111; r_rb = DEFRB;
    s_mask = 3'b111; s_stream = 3'b111; s_rb = DEFRB;
    m_fn = 0; m_idx = 0; m_busy = 0; prev_stall = 0; prev_data = 0; cap_fn = 0;
    repeat (3) @(negedge clk);
    check(hdr_valid == 1'b0 && hdr_last == 1'b0, "R1 reset outputs", {hdr_valid, hdr_last}, 0);
    rst = 1'b0;
    @(negedge clk);

    header();
    check(cap[2] == 8'h3F, "R1 default flags", cap[2], 8'h3F);
    check({cap[5], cap[6]} == DEFRB, "R1 default range", {cap[5], cap[6]}, DEFRB);
    check({cap[3], cap[4]} == 16'h0, "R8 first frame number", {cap[3], cap[4]}, 0);
    check(cap[0] == SYNC && cap[1] == VER, "R6 sync/version", {cap[0], cap[1]}, {SYNC, VER});

    cmd(8'h05, 16'h0000);
    header();
    check(cap[2] == 8'h38, "R5 mask 111 no streams", cap[2], 8'h38);

    cmd(8'h19, 16'hFFF5); cmd(8'h05, 16'h0002); cmd(8'h1A, 16'h1234);
    header();
    check(cap[2] == 8'h2A, "R2 mask/stream write", cap[2], 8'h2A);
    check({cap[5], cap[6]} == 16'h1234, "R2 range write", {cap[5], cap[6]}, 16'h1234);

    cmd(8'h18, 16'hFFFF); cmd(8'h00, 16'h0000); cmd(8'hFF, 16'h0007); cmd(8'h1B, 16'hDEAD);
    header();
    check(cap[2] == 8'h2A, "R3 unknown opcode flags", cap[2], 8'h2A);
    check({cap[5], cap[6]} == 16'h1234, "R3 unknown opcode range", {cap[5], cap[6]}, 16'h1234);

    // writes during a header, including at the capture edge
    step(1, 8'h19, 16'h0000, 1, 1);
    cmd(8'h1A, 16'hBEEF); cmd(8'h05, 16'h0005);
    for (int k = 0; k < 8; k++) idle_step();
    check(cap[2] == 8'h2A, "R4 snapshot flags", cap[2], 8'h2A);
    check({cap[5], cap[6]} == 16'h1234, "R4 snapshot range", {cap[5], cap[6]}, 16'h1234);
    header();
    check(cap[2] == 8'h05, "R4 later header flags", cap[2], 8'h05);
    check({cap[5], cap[6]} == 16'hBEEF, "R4 later header range", {cap[5], cap[6]}, 16'hBEEF);

    // stalls with frame_done held through the header
    prev_fn = cap_fn;
    step(0, 8'h00, 16'h0, 1, 0);
    for (int k = 0; k < 7; k++) begin
      step(0, 8'h00, 16'h0, 1, 0);
      step(0, 8'h00, 16'h0, 1, 0);
      step(0, 8'h00, 16'h0, 1, 1);
    end
    check(cap_fn == ((prev_fn + 1) & FMASK), "R9 single advance", cap_fn, (prev_fn + 1) & FMASK);
    for (int k = 0; k < 10; k++) idle_step();

    // wrap of the frame counter
    for (int h = 0; h < (1 << FCW); h++) begin
      prev_fn = m_fn;
      header();
      if (prev_fn == FMASK)
        check({cap[3], cap[4]} == 16'(FMASK) && m_fn == 0, "R8 wrap",
              {cap[3], cap[4]}, FMASK);
    end

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] op;
      case ($urandom % 4)
        0: op = 8'h05;
        1: op = 8'h19;
        2: op = 8'h1A;
        default: op = 8'($urandom);
      endcase
      step(($urandom % 4) == 0, op, 16'($urandom), ($urandom % 6) == 0, ($urandom % 3) != 0);
    end
    for (int k = 0; k < 10; k++) idle_step();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule